// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is a synthesizable model of the write-command front end of a parallel x16 NOR-style flash. The host drives chip-enable, write-enable, output-enable, an address and a data word. The inputs are sampled on a system clock. A host write cycle is any stretch in which chip-enable and write-enable are both low. The block decodes unlock and command sequences from these cycles. It then starts a word program, a sector erase or a block erase on a small behavioural array. While that internal operation runs, it asserts `busy`.

The address of a write cycle is taken in the first sampled cycle in which both strobes are low. This is the moment the later strobe fell. The data word is taken from the last sampled cycle before either strobe rises. An erase aimed at the protected block is dropped while the active-low write-protect input is low. A parameter picks the top or the bottom block as the protected one. Every command that arrives during an internal operation is dropped. The array comes out of reset fully erased. Reads return the addressed word one clock after chip-enable and output-enable are both low.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, `busy` is low and `rdData` is zero.
- R2: While `ceN` and `oeN` are both low, `rdData` shows the word at `addr` on the next clock edge. An erased word reads FFFFh.
- R3: A write cycle takes its address in its first clock in which `ceN` and `weN` are both low. This holds whichever strobe fell last. Address changes later in the cycle are ignored.
- R4: A write cycle takes its data word in its last clock before either strobe rises.
- R5: A word program is four write cycles: AAh to address 555h, 55h to 2AAh, A0h to 555h, then the target address and data. Only the low 8 data bits and the low 11 address bits of the three set-up cycles are compared. `busy` rises at the first clock edge after the fourth cycle ends and stays high for PROG_CYCLES clocks.
- R6: A program stores the old word AND the new data, so it can only turn ones into zeros.
- R7: A sector erase is six cycles: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any address in the sector. It sets every word of the aligned 2^SECTOR_W-word sector to FFFFh and leaves neighbouring words unchanged. `busy` lasts ERASE_CYCLES clocks.
- R8: The same six-cycle sequence with 50h in the last cycle erases the aligned 2^BLOCK_W-word block.
- R9: A set-up cycle with the wrong address or data returns the sequencer to idle with no change to the array. Later cycles of that sequence then have no effect.
- R10: A command sequence written while `busy` is high is ignored completely.
- R11: While `wpN` is low, a sector or block erase whose address lies in the protected block (the top block with PROTECT_TOP=1) is dropped, and `busy` stays low. The same erase proceeds with `wpN` high, and erases outside that block proceed with `wpN` low.
- R12: With `ceN` high, a low pulse on `weN` is not a write cycle and does not advance the sequencer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip enable |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| wpN | input | 1 | Active-low write protect for the protected block |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| busy | output | 1 | High while an internal program or erase runs |

## Verification
The hardest case to reach is a full, otherwise valid command arriving while an erase is still running. The bench starts a sector erase and, before the long busy window ends, writes a complete program sequence. It then reads that word once `busy` falls. The bench also builds write cycles whose address changes mid-cycle and whose data settles only in the last low clock. It writes a cycle where chip-enable falls after write-enable, and a write-enable pulse with the chip deselected. These show which sample of address and data each cycle actually uses.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef struct packed {
    logic capAddr;
    logic capData;
    logic goProg;
    logic goSector;
    logic goBlock;
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_PROG,
    S_ERA1,
    S_ERA2,
    S_ERA3
  } seq_state_t;

  localparam int CMD_ADDR_W = 11;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 16,
  parameter int BLOCK_W     = 8,
  parameter bit PROTECT_TOP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              wpN,
  input  logic              busy,
  input  logic [ADDR_W-1:0] latchAddr,
  input  logic [DATA_W-1:0] latchData,
  output strobe_t           strb
);

  localparam int BLK_IDX_W = ADDR_W - BLOCK_W;
  localparam logic [CMD_ADDR_W-1:0] KEY_A = CMD_ADDR_W'(11'h555);
  localparam logic [CMD_ADDR_W-1:0] KEY_B = CMD_ADDR_W'(11'h2AA);

  logic wrActive, wrPrev, cycEnd;
  seq_state_t state, nxtState;
  logic [CMD_ADDR_W-1:0] cmdAddr;
  logic [7:0] cmdByte;
  logic [BLK_IDX_W-1:0] blkIdx;
  logic inProt, blocked;

  assign wrActive = !ceN && !weN;
  assign cycEnd   = wrPrev && !wrActive;
  assign cmdAddr  = latchAddr[CMD_ADDR_W-1:0];
  assign cmdByte  = latchData[7:0];
  assign blkIdx   = latchAddr[ADDR_W-1:BLOCK_W];
  assign inProt   = PROTECT_TOP ? (blkIdx == '1) : (blkIdx == '0);
  assign blocked  = !wpN && inProt;

  function automatic logic hit(input logic [7:0] b, input logic [CMD_ADDR_W-1:0] a);
    return (cmdByte == b) && (cmdAddr == a);
  endfunction

  always_comb begin
    nxtState      = state;
    strb          = '0;
    strb.capAddr  = wrActive && !wrPrev;
    strb.capData  = wrActive;
    if (busy) begin
      nxtState = S_IDLE;
    end else if (cycEnd) begin
      nxtState = S_IDLE;
      unique case (state)
        S_IDLE: if (hit(8'hAA, KEY_A)) nxtState = S_UNL1;
        S_UNL1: if (hit(8'h55, KEY_B)) nxtState = S_UNL2;
        S_UNL2: begin
          if (hit(8'hA0, KEY_A))      nxtState = S_PROG;
          else if (hit(8'h80, KEY_A)) nxtState = S_ERA1;
        end
        S_PROG: strb.goProg = 1'b1;
        S_ERA1: if (hit(8'hAA, KEY_A)) nxtState = S_ERA2;
        S_ERA2: if (hit(8'h55, KEY_B)) nxtState = S_ERA3;
        S_ERA3: begin
          strb.goSector = (cmdByte == 8'h30) && !blocked;
          strb.goBlock  = (cmdByte == 8'h50) && !blocked;
        end
        default: nxtState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
      state  <= S_IDLE;
    end else begin
      wrPrev <= wrActive;
      state  <= nxtState;
    end
  end

  // R9: only one operation may start per cycle
  p_one_launch_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.goProg, strb.goSector, strb.goBlock}));

  // R9: a wrong second unlock cycle drops back to idle
  p_bad_to_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cycEnd && !busy && state == S_UNL1 && !(cmdByte == 8'h55 && cmdAddr == KEY_B))
    |=> state == S_IDLE);

  // R11: no erase starts inside the protected block while protection is on
  p_protect_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.goSector || strb.goBlock) && !wpN) |-> !inProt);

endmodule

// File: rtl/flash_array_dp.sv
module flash_array_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 16,
  parameter int SECTOR_W     = 4,
  parameter int BLOCK_W      = 8,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdEn,
  output logic [ADDR_W-1:0] latchAddr,
  output logic [DATA_W-1:0] latchData,
  output logic              busy,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int LIM_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW0     = $clog2(LIM_MAX + 1);
  localparam int CW      = (CW0 > ADDR_W + 1) ? CW0 : ADDR_W + 1;
  localparam logic [ADDR_W-1:0] SEC_MASK = ADDR_W'((1 << SECTOR_W) - 1);
  localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'((1 << BLOCK_W) - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  wordValid;
  logic [CW-1:0]     opCnt, opLimit;
  logic              erasing;
  logic [ADDR_W-1:0] eraseBase, eraseMask;
  logic              wrEn, wrKeep;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrVal;

  function automatic logic [DATA_W-1:0] effWord(input logic [ADDR_W-1:0] a);
    return wordValid[a] ? mem[a] : '1;
  endfunction

  always_comb begin
    wrEn   = 1'b0;
    wrKeep = 1'b0;
    wrAddr = latchAddr;
    wrVal  = effWord(latchAddr) & latchData;
    if (strb.goProg) begin
      wrEn   = 1'b1;
      wrKeep = 1'b1;
    end else if (busy && erasing && opCnt <= CW'(eraseMask)) begin
      wrEn   = 1'b1;
      wrAddr = eraseBase | opCnt[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn && wrKeep) mem[wrAddr] <= wrVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordValid <= '0;
      latchAddr <= '0;
      latchData <= '0;
      busy      <= 1'b0;
      opCnt     <= '0;
      opLimit   <= '0;
      erasing   <= 1'b0;
      eraseBase <= '0;
      eraseMask <= '0;
      rdData    <= '0;
    end else begin
      if (wrEn) wordValid[wrAddr] <= wrKeep;
      if (strb.capAddr) latchAddr <= addr;
      if (strb.capData) latchData <= dataIn;
      if (rdEn) rdData <= effWord(addr);
      if (strb.goProg) begin
        busy    <= 1'b1;
        opCnt   <= '0;
        opLimit <= CW'(PROG_CYCLES);
        erasing <= 1'b0;
      end else if (strb.goSector || strb.goBlock) begin
        busy      <= 1'b1;
        opCnt     <= '0;
        opLimit   <= CW'(ERASE_CYCLES);
        erasing   <= 1'b1;
        eraseMask <= strb.goBlock ? BLK_MASK : SEC_MASK;
        eraseBase <= latchAddr & ~(strb.goBlock ? BLK_MASK : SEC_MASK);
      end else if (busy) begin
        if (opCnt == opLimit - CW'(1)) busy <= 1'b0;
        opCnt <= opCnt + CW'(1);
      end
    end
  end

  // R10: the sequencer never launches into a running operation
  p_no_launch_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.goProg || strb.goSector || strb.goBlock));

  // R5: busy ends only when the full duration has elapsed
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(opCnt) == $past(opLimit) - CW'(1));

  // R5: a program launch is followed by a busy, non-erase operation
  p_prog_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.goProg |=> (busy && !erasing));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 16,
  parameter int SECTOR_W     = 4,
  parameter int BLOCK_W      = 8,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 300,
  parameter bit PROTECT_TOP  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              busy
);

  strobe_t strb;
  logic [ADDR_W-1:0] latchAddr;
  logic [DATA_W-1:0] latchData;
  logic rdEn;

  assign rdEn = !ceN && !oeN;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCK_W(BLOCK_W), .PROTECT_TOP(PROTECT_TOP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .wpN(wpN), .busy(busy),
    .latchAddr(latchAddr), .latchData(latchData), .strb(strb)
  );

  flash_array_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .dataIn(dataIn), .rdEn(rdEn),
    .latchAddr(latchAddr), .latchData(latchData), .busy(busy), .rdData(rdData)
  );

endmodule

// File: tb/flash_cmd_if_test.sv
module flash_cmd_if_test;

  localparam int AW = 11;
  localparam int DW = 16;
  localparam int PROGC = 20;
  localparam int ERAC = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, wpN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] rdData;
  logic busy;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_cmd_if #(.ADDR_W(AW), .DATA_W(DW), .SECTOR_W(4), .BLOCK_W(8),
    .PROG_CYCLES(PROGC), .ERASE_CYCLES(ERAC), .PROTECT_TOP(1'b1)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .wpN(wpN),
    .addr(addr), .dataIn(dataIn), .rdData(rdData), .busy(busy));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    repeat (2) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
  endtask

  task automatic progSeq(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(a, d);
  endtask

  task automatic eraseSeq(input logic [AW-1:0] a, input logic [7:0] cmd);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(a, {8'h00, cmd});
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk); d = rdData; ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 busy after reset", int'(busy), 0);
    check("R1 rdData after reset", int'(rdData), 0);
    rd(11'h000, d);
    check("R2 erased word reads ones", int'(d), 16'hFFFF);
  endtask

  task automatic t_program();
    logic [DW-1:0] d; int n;
    progSeq(11'h010, 16'h1234);
    waitIdle(n);
    check("R5 program busy length", n, PROGC);
    rd(11'h010, d);
    check("R5 programmed word", int'(d), 16'h1234);
    rd(11'h011, d);
    check("R2 neighbour still erased", int'(d), 16'hFFFF);
  endtask

  task automatic t_clearOnly();
    logic [DW-1:0] d; int n;
    progSeq(11'h010, 16'hFF00);
    waitIdle(n);
    rd(11'h010, d);
    check("R6 program only clears bits", int'(d), 16'h1200);
  endtask

  task automatic t_sectorErase();
    logic [DW-1:0] d; int n;
    progSeq(11'h020, 16'h0001); waitIdle(n);
    progSeq(11'h02F, 16'h0002); waitIdle(n);
    progSeq(11'h030, 16'h0003); waitIdle(n);
    eraseSeq(11'h025, 8'h30);
    waitIdle(n);
    check("R7 sector erase busy length", n, ERAC);
    rd(11'h020, d); check("R7 sector first word erased", int'(d), 16'hFFFF);
    rd(11'h02F, d); check("R7 sector last word erased", int'(d), 16'hFFFF);
    rd(11'h030, d); check("R7 next sector untouched", int'(d), 16'h0003);
    rd(11'h010, d); check("R7 other sector untouched", int'(d), 16'h1200);
  endtask

  task automatic t_blockErase();
    logic [DW-1:0] d; int n;
    progSeq(11'h110, 16'h0A0A); waitIdle(n);
    progSeq(11'h1FF, 16'h0B0B); waitIdle(n);
    progSeq(11'h200, 16'h0C0C); waitIdle(n);
    eraseSeq(11'h150, 8'h50);
    waitIdle(n);
    check("R8 block erase busy length", n, ERAC);
    rd(11'h110, d); check("R8 block word erased", int'(d), 16'hFFFF);
    rd(11'h1FF, d); check("R8 block end erased", int'(d), 16'hFFFF);
    rd(11'h200, d); check("R8 next block untouched", int'(d), 16'h0C0C);
    rd(11'h030, d); check("R8 previous block untouched", int'(d), 16'h0003);
  endtask

  task automatic t_badSeq();
    logic [DW-1:0] d; int n;
    wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055);
    check("R9 no busy after bad cycle", int'(busy), 0);
    wr(11'h555, 16'h00A0); wr(11'h040, 16'h0000);
    check("R9 no busy after rest of sequence", int'(busy), 0);
    waitIdle(n);
    rd(11'h040, d);
    check("R9 broken sequence leaves array", int'(d), 16'hFFFF);
  endtask

  task automatic t_busyIgnore();
    logic [DW-1:0] d; int n;
    eraseSeq(11'h300, 8'h30);
    check("R10 erase running", int'(busy), 1);
    progSeq(11'h050, 16'h0000);
    check("R10 still busy during ignored command", int'(busy), 1);
    waitIdle(n);
    rd(11'h050, d);
    check("R10 command during busy ignored", int'(d), 16'hFFFF);
  endtask

  task automatic t_protect();
    logic [DW-1:0] d; int n;
    progSeq(11'h7F0, 16'h0000); waitIdle(n);
    progSeq(11'h0E0, 16'h0000); waitIdle(n);
    wpN = 1'b0;
    eraseSeq(11'h7F3, 8'h30);
    check("R11 protected sector erase gives no busy", int'(busy), 0);
    rd(11'h7F0, d); check("R11 protected word kept", int'(d), 16'h0000);
    eraseSeq(11'h700, 8'h50);
    check("R11 protected block erase gives no busy", int'(busy), 0);
    eraseSeq(11'h0E0, 8'h30);
    waitIdle(n);
    rd(11'h0E0, d); check("R11 unprotected erase with wp low", int'(d), 16'hFFFF);
    wpN = 1'b1;
    eraseSeq(11'h7F3, 8'h30);
    waitIdle(n);
    rd(11'h7F0, d); check("R11 erase allowed with wp high", int'(d), 16'hFFFF);
  endtask

  task automatic t_latchEdges();
    logic [DW-1:0] d; int n;
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0);
    @(negedge clk); addr = 11'h060; dataIn = 16'hAAAA; ceN = 1'b0; weN = 1'b0;
    @(negedge clk); addr = 11'h061; dataIn = 16'h5A5A;
    @(negedge clk); ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    waitIdle(n);
    rd(11'h060, d); check("R4 data from last low clock", int'(d), 16'h5A5A);
    rd(11'h061, d); check("R3 later address ignored", int'(d), 16'hFFFF);
  endtask

  task automatic t_ceControl();
    logic [DW-1:0] d; int n;
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0);
    @(negedge clk); weN = 1'b0; addr = 11'h071; dataIn = 16'h0F0F;
    @(negedge clk); addr = 11'h070; ceN = 1'b0;
    repeat (2) @(negedge clk);
    ceN = 1'b1;
    @(negedge clk); weN = 1'b1;
    @(negedge clk);
    waitIdle(n);
    rd(11'h070, d); check("R3 address at later strobe fall", int'(d), 16'h0F0F);
    rd(11'h071, d); check("R3 address before chip enable ignored", int'(d), 16'hFFFF);
    @(negedge clk); addr = 11'h555; dataIn = 16'h00AA; weN = 1'b0;
    repeat (2) @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(11'h080, 16'h0000);
    check("R12 deselected pulse starts nothing", int'(busy), 0);
    waitIdle(n);
    rd(11'h080, d); check("R12 deselected pulse is not a write", int'(d), 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_clearOnly();
    t_sectorErase();
    t_blockErase();
    t_badSeq();
    t_busyIgnore();
    t_protect();
    t_latchEdges();
    t_ceControl();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule